// File: doc/BRIEF.md
# I2C Transfer Status Flag Tracker

This block follows an I2C bus from the side, through oversampled copies of SCL and SDA taken in the system clock domain. It finds start and stop conditions and counts SCL pulses inside each nine-clock byte frame. It also captures the first byte after every start or repeated start. From these events it keeps three status flags. The first says that the bus address matches the local address. The second says whether this node is the transmitter. The third records an acknowledge seen on the ninth clock. A fourth output tells the surrounding controller whether its data latch may drive SDA.

The controller gives the local address, an enable level, a role select (master or slave) and an arbitration-loss level. It also gives three one-cycle pulses. One releases the node from the current transfer. One cancels a wait after the ninth clock. One marks a start that the local master has just generated. Every pin is a plain level or pulse. No data stream crosses the boundary, so the block has no valid/ready handshake.

Top module: `i2c_flag_tracker`

## Requirements
- R1: After reset, and on every cycle after `enable` has been low, `addr_match`, `xmit`, `ack_seen` and `sda_oe` are all 0.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A stop clears `addr_match`, `xmit`, `ack_seen` and `sda_oe`.
- R3: The first byte after a start is taken MSB first. Its first seven bits are the address and its eighth bit is the direction bit (1 = the addressed slave transmits). `addr_match` sets at the rising edge of the eighth SCL clock when the address equals `local_addr`.
- R4: Bytes after the first byte never set `addr_match`, even when they carry the local address pattern.
- R5: `addr_match` clears on any start (including a repeated start) and on a `comm_save` pulse.
- R6: In slave role, `xmit` sets at the eighth rising edge of the first byte when the direction bit is 1. A detected start clears it.
- R7: In master role, `xmit` sets on a `master_start` pulse and a bus start does not clear it. It clears at the eighth rising edge of the first byte when the direction bit sent is 1.
- R8: `xmit` clears on a `wait_cancel` pulse, on a 0-to-1 change of `arb_lost`, and on a `comm_save` pulse. A clear wins over a set in the same cycle.
- R9: `sda_oe` is 1 only while `xmit` is 1 and driving is armed. In slave role it arms at the falling edge of the first byte's ninth clock. In master role it arms on `master_start`. A `wait_cancel` therefore releases SDA.
- R10: `ack_seen` sets when SDA is low at the rising edge of the ninth clock. It clears at the first rising edge of the next byte, on a stop and on `comm_save`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| enable | input | 1 | Tracker enable; low holds all state cleared |
| is_master | input | 1 | Role select: 1 master, 0 slave |
| local_addr | input | ADDR_W | Local slave address |
| comm_save | input | 1 | One-cycle pulse: leave the current transfer |
| wait_cancel | input | 1 | One-cycle pulse: cancel the wait after the ninth clock |
| arb_lost | input | 1 | Arbitration-loss level from the master logic |
| master_start | input | 1 | One-cycle pulse: local master generated a start |
| addr_match | output | 1 | First byte carried the local address |
| xmit | output | 1 | This node is the transmitter |
| ack_seen | output | 1 | Acknowledge seen on the last ninth clock |
| sda_oe | output | 1 | Data latch may drive SDA |

## Verification
The assertions take as given that every SCL and SDA level lasts longer than the synchronizer depth plus one clock. Under that condition each bus edge becomes exactly one event pulse. They also take as given that `comm_save`, `wait_cancel` and `master_start` are single-cycle pulses. The stimulus holds every bus phase for six clocks, changes SDA only while SCL is low except when forming starts and stops, and drives each control pulse for exactly one clock on the falling clock edge.

// File: rtl/i2c_flag_pkg.sv
package i2c_flag_pkg;

  // Events derived from the synchronized bus lines, one cycle wide.
  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
    logic sda;      // synchronized SDA level
  } line_ev_t;

  // Events derived from position within the byte frame.
  typedef struct packed {
    logic addr_done;   // rising edge of the direction-bit clock, first byte only
    logic ack_clk;     // rising edge of the acknowledge clock
    logic first_clk;   // rising edge of clock 1 of a following byte
    logic ack_fall;    // falling edge of the acknowledge clock
    logic first_byte;  // inside the first byte after a start
  } frame_ev_t;

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler
  import i2c_flag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_in,
  input  logic     sda_in,
  output line_ev_t ev
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic                   scl_d;
  logic                   sda_d;
  logic                   scl_s;
  logic                   sda_s;

  // Idle bus is high, so the chain resets to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe[0] <= scl_in;
      sda_pipe[0] <= sda_in;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        scl_pipe[i] <= scl_pipe[i-1];
        sda_pipe[i] <= sda_pipe[i-1];
      end
      scl_d <= scl_pipe[LAST];
      sda_d <= sda_pipe[LAST];
    end
  end

  assign scl_s = scl_pipe[LAST];
  assign sda_s = sda_pipe[LAST];

  always_comb begin
    ev.scl_rise = scl_s & ~scl_d;
    ev.scl_fall = ~scl_s & scl_d;
    ev.start    = scl_s & scl_d & sda_d & ~sda_s;
    ev.stop     = scl_s & scl_d & ~sda_d & sda_s;
    ev.sda      = sda_s;
  end

endmodule

// File: rtl/i2c_frame_counter.sv
module i2c_frame_counter
  import i2c_flag_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  line_ev_t          ev,
  output frame_ev_t         fev,
  output logic [ADDR_W-1:0] rx_addr,
  output logic              rx_dir
);

  localparam int FRAME = ADDR_W + 2;            // data bits plus acknowledge
  localparam int CNT_W = $clog2(FRAME + 1);
  localparam logic [CNT_W-1:0] DIR_POS  = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] ACK_POS  = CNT_W'(ADDR_W + 1);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME);

  // cnt holds the number of clocks already seen in this frame.
  logic [CNT_W-1:0]  cnt;
  logic              first_byte;
  logic [ADDR_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      first_byte <= 1'b0;
      shreg      <= '0;
    end else if (!enable) begin
      cnt        <= '0;
      first_byte <= 1'b0;
    end else if (ev.start) begin
      cnt        <= '0;
      first_byte <= 1'b1;
    end else if (ev.stop) begin
      cnt        <= '0;
      first_byte <= 1'b0;
    end else if (ev.scl_rise) begin
      if (cnt == LAST_POS) begin
        cnt        <= CNT_W'(1);
        first_byte <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
      if (cnt < DIR_POS) begin
        shreg <= {shreg[ADDR_W-2:0], ev.sda};
      end
    end
  end

  assign rx_addr = shreg;
  assign rx_dir  = ev.sda;

  always_comb begin
    fev.addr_done  = enable & ev.scl_rise & (cnt == DIR_POS) & first_byte;
    fev.ack_clk    = enable & ev.scl_rise & (cnt == ACK_POS);
    fev.first_clk  = enable & ev.scl_rise & (cnt == LAST_POS);
    fev.ack_fall   = enable & ev.scl_fall & (cnt == LAST_POS);
    fev.first_byte = first_byte;
  end

endmodule

// File: rtl/i2c_status_flags.sv
module i2c_status_flags
  import i2c_flag_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              is_master,
  input  logic [ADDR_W-1:0] local_addr,
  input  logic              comm_save,
  input  logic              wait_cancel,
  input  logic              arb_lost,
  input  logic              master_start,
  input  line_ev_t          ev,
  input  frame_ev_t         fev,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic              rx_dir,
  output logic              addr_match,
  output logic              xmit,
  output logic              ack_seen,
  output logic              sda_oe
);

  logic arb_d;
  logic armed;
  logic arb_rise;
  logic common_clr;
  logic match_clr, match_set;
  logic xmit_clr, xmit_set;
  logic ack_clr, ack_set;
  logic arm_clr, arm_set;

  assign arb_rise   = arb_lost & ~arb_d;
  assign common_clr = ~enable | ev.stop | comm_save;

  always_comb begin
    match_clr = common_clr | ev.start;
    match_set = fev.addr_done & (rx_addr == local_addr);

    xmit_clr  = common_clr | wait_cancel | arb_rise
              | (~is_master & ev.start)
              | (is_master & fev.addr_done & rx_dir);
    xmit_set  = (is_master & master_start)
              | (~is_master & fev.addr_done & rx_dir);

    ack_clr   = common_clr | fev.first_clk;
    ack_set   = fev.ack_clk & ~ev.sda;

    arm_clr   = common_clr | (~is_master & ev.start);
    arm_set   = (is_master & master_start) | fev.ack_fall;
  end

  // Clear events take priority over set events in every flag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arb_d      <= 1'b0;
      addr_match <= 1'b0;
      xmit       <= 1'b0;
      ack_seen   <= 1'b0;
      armed      <= 1'b0;
    end else begin
      arb_d <= arb_lost;
      if (match_clr)      addr_match <= 1'b0;
      else if (match_set) addr_match <= 1'b1;
      if (xmit_clr)       xmit <= 1'b0;
      else if (xmit_set)  xmit <= 1'b1;
      if (ack_clr)        ack_seen <= 1'b0;
      else if (ack_set)   ack_seen <= 1'b1;
      if (arm_clr)        armed <= 1'b0;
      else if (arm_set)   armed <= 1'b1;
    end
  end

  assign sda_oe = xmit & armed;

endmodule

// File: rtl/i2c_flag_tracker.sv
module i2c_flag_tracker
  import i2c_flag_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              enable,
  input  logic              is_master,
  input  logic [ADDR_W-1:0] local_addr,
  input  logic              comm_save,
  input  logic              wait_cancel,
  input  logic              arb_lost,
  input  logic              master_start,
  output logic              addr_match,
  output logic              xmit,
  output logic              ack_seen,
  output logic              sda_oe
);

  line_ev_t          ev;
  frame_ev_t         fev;
  logic [ADDR_W-1:0] rx_addr;
  logic              rx_dir;

  i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_in (scl_in),
    .sda_in (sda_in),
    .ev     (ev)
  );

  i2c_frame_counter #(.ADDR_W(ADDR_W)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .ev      (ev),
    .fev     (fev),
    .rx_addr (rx_addr),
    .rx_dir  (rx_dir)
  );

  i2c_status_flags #(.ADDR_W(ADDR_W)) u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .is_master    (is_master),
    .local_addr   (local_addr),
    .comm_save    (comm_save),
    .wait_cancel  (wait_cancel),
    .arb_lost     (arb_lost),
    .master_start (master_start),
    .ev           (ev),
    .fev          (fev),
    .rx_addr      (rx_addr),
    .rx_dir       (rx_dir),
    .addr_match   (addr_match),
    .xmit         (xmit),
    .ack_seen     (ack_seen),
    .sda_oe       (sda_oe)
  );

endmodule

// File: rtl/i2c_flag_tracker_chk.sv
module i2c_flag_tracker_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic comm_save,
  input logic wait_cancel,
  input logic arb_lost,
  input logic stop_ev,
  input logic addr_ev,
  input logic ack_ev,
  input logic addr_match,
  input logic xmit,
  input logic ack_seen,
  input logic sda_oe
);

  // R1
  disabled_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!addr_match && !xmit && !ack_seen && !sda_oe));

  // R2
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!addr_match && !xmit && !ack_seen && !sda_oe));

  // R3
  match_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_match) |-> $past(addr_ev));

  // R5
  save_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comm_save |=> (!addr_match && !xmit && !ack_seen));

  // R8
  wait_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cancel |=> (!xmit && !sda_oe));

  // R8
  arb_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && !$past(arb_lost)) |=> !xmit);

  // R9
  drive_needs_xmit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> xmit);

  // R10
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_seen) |-> $past(ack_ev));

endmodule

bind i2c_flag_tracker i2c_flag_tracker_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .comm_save   (comm_save),
  .wait_cancel (wait_cancel),
  .arb_lost    (arb_lost),
  .stop_ev     (ev.stop),
  .addr_ev     (fev.addr_done),
  .ack_ev      (fev.ack_clk),
  .addr_match  (addr_match),
  .xmit        (xmit),
  .ack_seen    (ack_seen),
  .sda_oe      (sda_oe)
);

// File: tb/test_i2c_flag_tracker.sv
module test_i2c_flag_tracker;

  localparam int HOLD = 6;

  typedef struct {
    string      tag;
    logic [3:0] exp;   // {addr_match, xmit, ack_seen, sda_oe}
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic enable = 1'b1, is_master = 1'b0;
  logic [6:0] local_addr = 7'h2A;
  logic comm_save = 1'b0, wait_cancel = 1'b0, arb_lost = 1'b0, master_start = 1'b0;
  logic addr_match, xmit, ack_seen, sda_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  item_t sb[$];

  always #4 clk = ~clk;

  i2c_flag_tracker i_i2c_flag_tracker (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
    .enable(enable), .is_master(is_master), .local_addr(local_addr),
    .comm_save(comm_save), .wait_cancel(wait_cancel), .arb_lost(arb_lost),
    .master_start(master_start), .addr_match(addr_match), .xmit(xmit),
    .ack_seen(ack_seen), .sda_oe(sda_oe)
  );

  // Monitor: pops expected items and compares away from the active edge.
  initial begin
    forever begin
      wait (sb.size() > 0);
      @(negedge clk);
      begin
        item_t it;
        logic [3:0] act;
        it  = sb.pop_front();
        act = {addr_match, xmit, ack_seen, sda_oe};
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: {match,xmit,ack,oe} actual %b expected %b", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_st(input string tag, input logic [3:0] exp);
    item_t it;
    it.tag = tag;
    it.exp = exp;
    sb.push_back(it);
    wait (sb.size() == 0);
    @(posedge clk);
  endtask

  task automatic hold();
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic bus_start();
    sda = 1'b1; hold();
    scl = 1'b1; hold();
    sda = 1'b0; hold();
    scl = 1'b0; hold();
  endtask

  task automatic bus_stop();
    sda = 1'b0; hold();
    scl = 1'b1; hold();
    sda = 1'b1; hold();
  endtask

  task automatic bus_bit(input logic b);
    sda = b;    hold();
    scl = 1'b1; hold();
    scl = 1'b0; hold();
  endtask

  task automatic bus_bits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) bus_bit(v[i]);
  endtask

  task automatic pulse_save();
    @(negedge clk) comm_save = 1'b1;
    @(negedge clk) comm_save = 1'b0;
    hold();
  endtask

  task automatic pulse_wait();
    @(negedge clk) wait_cancel = 1'b1;
    @(negedge clk) wait_cancel = 1'b0;
    hold();
  endtask

  task automatic pulse_mstart();
    @(negedge clk) master_start = 1'b1;
    @(negedge clk) master_start = 1'b0;
    hold();
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    hold();
    expect_st("R1 reset", 4'b0000);

    // Slave read of local address 0x2A (first byte 0x55)
    bus_start();
    bus_bits(8'h55, 8);
    expect_st("R3 R6 match and xmit at 8th clock, R9 not yet driving", 4'b1100);
    bus_bit(1'b0);
    expect_st("R10 ack seen, R9 driving after 9th fall", 4'b1111);
    bus_bit(1'b1);
    expect_st("R10 ack cleared at next byte clock 1", 4'b1101);
    bus_bits(8'hFF, 7);
    bus_bit(1'b1);
    expect_st("R10 no ack on high SDA", 4'b1101);
    bus_stop();
    expect_st("R2 stop clears", 4'b0000);

    // Other address, write; later byte carries the local pattern
    bus_start();
    bus_bits(8'h2A, 8);
    expect_st("R3 mismatch", 4'b0000);
    bus_bit(1'b0);
    expect_st("R10 ack on mismatch byte", 4'b0010);
    bus_bits(8'h55, 8);
    expect_st("R4 later byte ignored", 4'b0000);
    bus_bit(1'b0);

    // Repeated start, local write, then communication save
    bus_start();
    expect_st("R5 repeated start clears", 4'b0000);
    bus_bits(8'h54, 8);
    expect_st("R3 match with write direction", 4'b1000);
    pulse_save();
    expect_st("R5 comm save clears", 4'b0000);
    bus_stop();

    // Wait cancel
    bus_start();
    bus_bits(8'h55, 8);
    bus_bit(1'b0);
    expect_st("R9 driving before wait cancel", 4'b1111);
    pulse_wait();
    expect_st("R8 wait cancel releases", 4'b1010);
    bus_stop();

    // Arbitration loss, then start clearing in slave role
    bus_start();
    bus_bits(8'h55, 8);
    @(negedge clk) arb_lost = 1'b1;
    hold();
    expect_st("R8 arbitration loss clears xmit", 4'b1000);
    arb_lost = 1'b0;
    bus_bit(1'b1);
    bus_start();
    bus_bits(8'h55, 8);
    expect_st("R6 xmit set again", 4'b1100);
    bus_start();
    expect_st("R6 slave start clears xmit", 4'b0000);

    // Enable drop
    bus_bits(8'h55, 8);
    @(negedge clk) enable = 1'b0;
    hold();
    expect_st("R1 enable low clears", 4'b0000);
    enable = 1'b1;
    bus_bit(1'b1);
    bus_stop();

    // Master role
    is_master = 1'b1;
    pulse_mstart();
    expect_st("R7 master start sets xmit, R9 drives", 4'b0101);
    bus_start();
    expect_st("R7 bus start keeps xmit", 4'b0101);
    bus_bits(8'h0B, 8);
    expect_st("R7 read bit clears xmit", 4'b0000);
    bus_bit(1'b0);
    expect_st("R10 master sees ack", 4'b0010);
    bus_stop();
    pulse_mstart();
    bus_start();
    bus_bits(8'h0A, 8);
    expect_st("R7 write bit keeps xmit", 4'b0101);
    pulse_save();
    expect_st("R8 comm save clears xmit", 4'b0000);
    bus_stop();
    is_master = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule